// File: doc/BRIEF.md
# Vector Length Control Register Unit

This unit holds the two registers that govern how many elements a vectorised register operation covers on a scalar core. The first is a maximum length, which software may rewrite at run time but which can never exceed XLEN. The second is the current length, which can never exceed the maximum. A simple CSR access port reaches them through three addresses. The maximum-length address behaves as a standard CSR. The clamping alias of the current length stores the smaller of the request and the maximum, and hands that stored value back as the result. The shadow alias of the current length reaches the same storage but returns the previous value, as a standard CSR does.

An access presents the address, an operation code, write data and an immediate select with a 5-bit immediate, all qualified by a valid strobe. The read value and an illegal-access flag are combinational in the same cycle. The stored lengths are registered and appear on the `cur_len` and `max_len` outputs after the next rising clock edge. The core can therefore set the length in one operation, including the immediate form for lengths 0 to 31.

Top module: `vlen_csr_unit`

## Requirements
- R1: After reset, `max_len` equals XLEN and `cur_len` equals 1. The reset is asynchronous, active low and released through a two-stage synchroniser.
- R2: A write (op 2'b01) to the clamping alias (`ADDR_CLAMP`) stores MIN(requested, `max_len`). The stored value equals the request exactly whenever the request does not exceed the maximum, and it appears on `cur_len` after the next rising edge.
- R3: A write, set or clear on the clamping alias returns the clamped new length on `csr_rdata` in the same cycle as the access.
- R4: A write to the shadow alias (`ADDR_SHADOW`) stores MIN(requested, `max_len`), but `csr_rdata` returns the previous current length.
- R5: Set (op 2'b10) computes old OR operand, and clear (op 2'b11) computes old AND NOT operand. On either length alias, the result is then clamped to `max_len` before it is stored. The clamping alias returns the stored result, while the shadow alias and the maximum-length address return the old value.
- R6: When `csr_use_imm` is 1, the operand is `csr_imm` zero-extended to XLEN (values 0 to 31), and `csr_wdata` has no effect.
- R7: An access to `ADDR_MAX` stores its result clamped to XLEN and returns the previous maximum on `csr_rdata`.
- R8: If a new maximum is below the current length, `cur_len` drops to the new maximum on the same clock edge as `max_len` changes.
- R9: A requested length of 0 is stored as 0 through either length alias.
- R10: A valid access to any other address raises `csr_illegal` in the same cycle, returns 0 and leaves both lengths unchanged. The flag is 0 for the three known addresses.
- R11: A read (op 2'b00) returns the addressed register's current value and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Access strobe, one access per cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csr_wdata | input | XLEN | Register operand |
| csr_use_imm | input | 1 | Select the 5-bit immediate as operand |
| csr_imm | input | 5 | Immediate operand, zero-extended |
| csr_rdata | output | XLEN | Value returned to the destination register (same cycle) |
| csr_illegal | output | 1 | Access to an unknown address (same cycle) |
| cur_len | output | $clog2(XLEN)+1 | Current vector length |
| max_len | output | $clog2(XLEN)+1 | Maximum vector length |

## Verification
`csr_rdata` and `csr_illegal` are due in the same cycle as the access. `cur_len` and `max_len` are due one rising edge later. The driver therefore queues each expectation with the cycle number at which it falls due: the return value for the access cycle, and the lengths for the cycle after. The monitor samples 2 ns after each falling edge and pops only the items that are due by then. This keeps every comparison clear of the active edge, and it lets back-to-back accesses check both the value returned against the old state and the state that follows.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  typedef enum logic [1:0] {
    VL_READ  = 2'b00,
    VL_WRITE = 2'b01,
    VL_SET   = 2'b10,
    VL_CLEAR = 2'b11
  } vl_op_e;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_MAX    = 2'd1,
    TGT_CLAMP  = 2'd2,
    TGT_SHADOW = 2'd3
  } vl_tgt_e;

  localparam logic [11:0] DEF_ADDR_MAX    = 12'h8C0;
  localparam logic [11:0] DEF_ADDR_CLAMP  = 12'h8C1;
  localparam logic [11:0] DEF_ADDR_SHADOW = 12'h8C2;

endpackage

// File: rtl/vlen_csr_decode.sv
module vlen_csr_decode
  import vlen_pkg::*;
#(
  parameter int          XLEN        = 64,
  parameter int          AW          = 12,
  parameter int          IMM_W       = 5,
  parameter logic [11:0] ADDR_MAX    = DEF_ADDR_MAX,
  parameter logic [11:0] ADDR_CLAMP  = DEF_ADDR_CLAMP,
  parameter logic [11:0] ADDR_SHADOW = DEF_ADDR_SHADOW
) (
  input  logic             valid_i,
  input  logic [AW-1:0]    addr_i,
  input  vl_op_e           op_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  output vl_tgt_e          tgt_o,
  output logic             illegal_o,
  output logic             wr_en_o,
  output logic [XLEN-1:0]  operand_o
);

  localparam int PAD_W = XLEN - IMM_W;

  always_comb begin
    if (addr_i == ADDR_MAX)         tgt_o = TGT_MAX;
    else if (addr_i == ADDR_CLAMP)  tgt_o = TGT_CLAMP;
    else if (addr_i == ADDR_SHADOW) tgt_o = TGT_SHADOW;
    else                            tgt_o = TGT_NONE;
  end

  always_comb begin
    illegal_o = valid_i && (tgt_o == TGT_NONE);
    wr_en_o   = valid_i && (tgt_o != TGT_NONE) && (op_i != VL_READ);
    operand_o = use_imm_i ? {{PAD_W{1'b0}}, imm_i} : wdata_i;
  end

  // R10: an unknown address never produces a write enable
  always_comb begin
    if (illegal_o) a_no_write_on_illegal_r10: assert (!wr_en_o);
  end

endmodule

// File: rtl/vlen_csr_alu.sv
module vlen_csr_alu
  import vlen_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vl_op_e          op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] operand_i,
  output logic [XLEN-1:0] raw_o
);

  always_comb begin
    unique case (op_i)
      VL_WRITE: raw_o = operand_i;
      VL_SET:   raw_o = old_i | operand_i;
      VL_CLEAR: raw_o = old_i & ~operand_i;
      default:  raw_o = old_i;
    endcase
  end

endmodule

// File: rtl/vlen_clamp.sv
module vlen_clamp #(
  parameter int XLEN = 64,
  parameter int LW   = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic [LW-1:0]   limit_i,
  output logic [LW-1:0]   value_o
);

  localparam int PAD_W = XLEN - LW;

  logic [XLEN-1:0] limit_x;

  always_comb begin
    limit_x = {{PAD_W{1'b0}}, limit_i};
    value_o = (raw_i > limit_x) ? limit_i : raw_i[LW-1:0];
  end

endmodule

// File: rtl/vlen_len_regs.sv
module vlen_len_regs #(
  parameter int XLEN = 64,
  parameter int LW   = $clog2(XLEN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          max_en_i,
  input  logic [LW-1:0] max_d_i,
  input  logic          cur_en_i,
  input  logic [LW-1:0] cur_d_i,
  output logic [LW-1:0] max_q_o,
  output logic [LW-1:0] cur_q_o
);

  localparam logic [LW-1:0] MAX_RST = LW'(XLEN);
  localparam logic [LW-1:0] CUR_RST = LW'(1);

  logic [LW-1:0] max_q, max_n;
  logic [LW-1:0] cur_q, cur_n;

  always_comb begin
    max_n = max_en_i ? max_d_i : max_q;
    cur_n = cur_en_i ? cur_d_i : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= MAX_RST;
      cur_q <= CUR_RST;
    end else begin
      max_q <= max_n;
      cur_q <= cur_n;
    end
  end

  assign max_q_o = max_q;
  assign cur_q_o = cur_q;

  // R7: the maximum never passes XLEN
  p_max_within_xlen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    max_q <= MAX_RST);

  // R8: the current length never passes the maximum
  p_cur_within_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= max_q);

  // R11: with no enable both registers hold
  p_hold_without_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!max_en_i && !cur_en_i) |=> ($stable(max_q) && $stable(cur_q)));

endmodule

// File: rtl/vlen_csr_unit.sv
module vlen_csr_unit
  import vlen_pkg::*;
#(
  parameter int          XLEN        = 64,
  parameter int          AW          = 12,
  parameter int          IMM_W       = 5,
  parameter logic [11:0] ADDR_MAX    = DEF_ADDR_MAX,
  parameter logic [11:0] ADDR_CLAMP  = DEF_ADDR_CLAMP,
  parameter logic [11:0] ADDR_SHADOW = DEF_ADDR_SHADOW,
  parameter int          LW          = $clog2(XLEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_valid,
  input  logic [AW-1:0]    csr_addr,
  input  logic [1:0]       csr_op,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic             csr_use_imm,
  input  logic [IMM_W-1:0] csr_imm,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_illegal,
  output logic [LW-1:0]    cur_len,
  output logic [LW-1:0]    max_len
);

  localparam int            PAD_W  = XLEN - LW;
  localparam logic [LW-1:0] XLEN_L = LW'(XLEN);

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  vl_op_e          op;
  vl_tgt_e         tgt;
  logic            wr_en;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] old_sel, raw;
  logic [XLEN-1:0] cur_x, max_x;
  logic [LW-1:0]   max_q, cur_q;
  logic [LW-1:0]   max_new, cur_new, cur_trim;
  logic            max_en, cur_en;
  logic [LW-1:0]   cur_d;

  assign op = vl_op_e'(csr_op);

  vlen_csr_decode #(
    .XLEN(XLEN), .AW(AW), .IMM_W(IMM_W),
    .ADDR_MAX(ADDR_MAX), .ADDR_CLAMP(ADDR_CLAMP), .ADDR_SHADOW(ADDR_SHADOW)
  ) i_decode (
    .valid_i   (csr_valid),
    .addr_i    (csr_addr),
    .op_i      (op),
    .wdata_i   (csr_wdata),
    .use_imm_i (csr_use_imm),
    .imm_i     (csr_imm),
    .tgt_o     (tgt),
    .illegal_o (csr_illegal),
    .wr_en_o   (wr_en),
    .operand_o (operand)
  );

  always_comb begin
    cur_x   = {{PAD_W{1'b0}}, cur_q};
    max_x   = {{PAD_W{1'b0}}, max_q};
    old_sel = (tgt == TGT_MAX) ? max_x : cur_x;
  end

  vlen_csr_alu #(.XLEN(XLEN)) i_alu (
    .op_i      (op),
    .old_i     (old_sel),
    .operand_i (operand),
    .raw_o     (raw)
  );

  // new maximum, saturated at XLEN
  vlen_clamp #(.XLEN(XLEN), .LW(LW)) i_clamp_max (
    .raw_i   (raw),
    .limit_i (XLEN_L),
    .value_o (max_new)
  );

  // current length trimmed to the incoming maximum
  vlen_clamp #(.XLEN(XLEN), .LW(LW)) i_clamp_trim (
    .raw_i   (cur_x),
    .limit_i (max_new),
    .value_o (cur_trim)
  );

  // requested current length, saturated at the present maximum
  vlen_clamp #(.XLEN(XLEN), .LW(LW)) i_clamp_cur (
    .raw_i   (raw),
    .limit_i (max_q),
    .value_o (cur_new)
  );

  always_comb begin
    max_en = wr_en && (tgt == TGT_MAX);
    cur_en = wr_en;
    cur_d  = (tgt == TGT_MAX) ? cur_trim : cur_new;
  end

  vlen_len_regs #(.XLEN(XLEN), .LW(LW)) i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .max_en_i (max_en),
    .max_d_i  (max_new),
    .cur_en_i (cur_en),
    .cur_d_i  (cur_d),
    .max_q_o  (max_q),
    .cur_q_o  (cur_q)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_valid) begin
      unique case (tgt)
        TGT_MAX:    csr_rdata = max_x;
        TGT_SHADOW: csr_rdata = cur_x;
        TGT_CLAMP:  csr_rdata = (op == VL_READ) ? cur_x : {{PAD_W{1'b0}}, cur_new};
        default:    csr_rdata = '0;
      endcase
    end
  end

  assign cur_len = cur_q;
  assign max_len = max_q;

  // R3: the clamping alias returns exactly what lands in the register
  p_clamp_returns_stored_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (csr_valid && csr_addr == ADDR_CLAMP && csr_op != 2'b00)
      |=> ({{PAD_W{1'b0}}, cur_len} == $past(csr_rdata)));

  // R4: the shadow alias returns the length held before the access
  p_shadow_returns_old_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (csr_valid && csr_addr == ADDR_SHADOW) |-> (csr_rdata == {{PAD_W{1'b0}}, cur_len}));

  // R10: an unknown address leaves both lengths alone
  p_illegal_holds_state_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (csr_valid && csr_illegal) |=> ($stable(cur_len) && $stable(max_len)));

  // R11: a read changes nothing
  p_read_holds_state_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (csr_valid && csr_op == 2'b00) |=> ($stable(cur_len) && $stable(max_len)));

  // R8: a lowered maximum pulls the current length down on the same edge
  p_trim_on_max_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (csr_valid && csr_addr == ADDR_MAX && csr_op != 2'b00)
      |=> (cur_len <= max_len));

endmodule

// File: tb/test_vlen_csr_unit.sv
module test_vlen_csr_unit;

  localparam int          XLEN = 64;
  localparam int          LW   = 7;
  localparam logic [11:0] A_MAX = 12'h8C0;
  localparam logic [11:0] A_CLP = 12'h8C1;
  localparam logic [11:0] A_SHD = 12'h8C2;
  localparam logic [1:0]  OP_RD = 2'b00, OP_WR = 2'b01, OP_SET = 2'b10, OP_CLR = 2'b11;

  logic            clk;
  logic            rst_n;
  logic            csr_valid;
  logic [11:0]     csr_addr;
  logic [1:0]      csr_op;
  logic [XLEN-1:0] csr_wdata;
  logic            csr_use_imm;
  logic [4:0]      csr_imm;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal;
  logic [LW-1:0]   cur_len;
  logic [LW-1:0]   max_len;

  vlen_csr_unit i_vlen_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_use_imm(csr_use_imm),
    .csr_imm(csr_imm), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .cur_len(cur_len), .max_len(max_len)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // scoreboard: kind 0 = return value and flag, kind 1 = lengths
  int          q_kind[$];
  int          q_due[$];
  logic [63:0] q_a[$];
  logic [63:0] q_c[$];
  string       q_tag[$];

  logic [63:0] m_max, m_cur;

  task automatic push(input int k, input int due, input logic [63:0] a,
                      input logic [63:0] c, input string tag);
    q_kind.push_back(k); q_due.push_back(due);
    q_a.push_back(a); q_c.push_back(c); q_tag.push_back(tag);
  endtask

  task automatic access(input logic [11:0] addr, input logic [1:0] op,
                        input logic [63:0] wd, input logic ui,
                        input logic [4:0] im, input string tag);
    logic [63:0] opnd, old, raw, ret, nv;
    bit legal;
    @(negedge clk);
    csr_valid = 1'b1; csr_addr = addr; csr_op = op;
    csr_wdata = wd; csr_use_imm = ui; csr_imm = im;
    opnd  = ui ? {59'd0, im} : wd;
    legal = (addr == A_MAX) || (addr == A_CLP) || (addr == A_SHD);
    old   = (addr == A_MAX) ? m_max : m_cur;
    case (op)
      OP_WR:   raw = opnd;
      OP_SET:  raw = old | opnd;
      OP_CLR:  raw = old & ~opnd;
      default: raw = old;
    endcase
    ret = old;
    if (!legal) ret = 64'd0;
    else if (op != OP_RD) begin
      if (addr == A_MAX) begin
        nv = (raw > 64'd64) ? 64'd64 : raw;
        m_max = nv;
        if (m_cur > nv) m_cur = nv;
      end else begin
        nv = (raw > m_max) ? m_max : raw;
        m_cur = nv;
        if (addr == A_CLP) ret = nv;
      end
    end
    push(0, cyc, ret, {63'd0, !legal}, tag);
    push(1, cyc + 1, m_cur, m_max, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    csr_valid = 1'b0; csr_op = OP_RD; csr_addr = 12'h000;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      int          k;
      logic [63:0] a, c;
      string       t;
      k = q_kind.pop_front(); void'(q_due.pop_front());
      a = q_a.pop_front(); c = q_c.pop_front(); t = q_tag.pop_front();
      if (k == 0) begin
        check(t, "csr_rdata", csr_rdata, a);
        check(t, "csr_illegal", {63'd0, csr_illegal}, c);
      end else begin
        check(t, "cur_len", {57'd0, cur_len}, a);
        check(t, "max_len", {57'd0, max_len}, c);
      end
    end
  end

  initial begin
    csr_valid = 0; csr_addr = 0; csr_op = 0; csr_wdata = 0;
    csr_use_imm = 0; csr_imm = 0;
    m_max = 64; m_cur = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    push(1, cyc, 64'd1, 64'd64, "R1 reset");

    access(A_CLP, OP_WR, 64'd10, 0, 5'd0, "R2 R3 write within max");
    access(A_CLP, OP_WR, 64'd100, 0, 5'd0, "R2 R3 write above max");
    access(A_MAX, OP_WR, 64'd20, 0, 5'd0, "R7 R8 lower max below cur");
    access(A_MAX, OP_WR, 64'd200, 0, 5'd0, "R7 max saturates at XLEN");
    access(A_SHD, OP_WR, 64'd40, 0, 5'd0, "R4 shadow write");
    access(A_SHD, OP_WR, 64'd100, 0, 5'd0, "R4 shadow write clamped");
    access(A_MAX, OP_WR, 64'd48, 0, 5'd0, "R8 trim to 48");
    access(A_CLP, OP_WR, 64'd5, 0, 5'd0, "R2 write 5");
    access(A_CLP, OP_SET, 64'd3, 0, 5'd0, "R5 clamp alias set");
    access(A_CLP, OP_CLR, 64'd2, 0, 5'd0, "R5 clamp alias clear");
    access(A_SHD, OP_SET, 64'h40, 0, 5'd0, "R5 shadow set clamped");
    access(A_SHD, OP_CLR, 64'h20, 0, 5'd0, "R5 shadow clear");
    access(A_MAX, OP_CLR, 64'h10, 0, 5'd0, "R5 R8 max clear");
    access(A_MAX, OP_SET, 64'h3F, 0, 5'd0, "R5 R7 max set");
    access(A_CLP, OP_WR, 64'hFFFF_FFFF_FFFF_FFFF, 1, 5'd31, "R6 imm 31 ignores wdata");
    access(A_SHD, OP_WR, 64'd0, 1, 5'd17, "R6 shadow imm 17");
    access(A_CLP, OP_WR, 64'd0, 0, 5'd0, "R9 zero via clamp alias");
    access(A_SHD, OP_WR, 64'd33, 0, 5'd0, "R4 shadow from zero");
    access(A_SHD, OP_WR, 64'd0, 1, 5'd0, "R9 zero via shadow imm");
    access(12'h123, OP_WR, 64'd7, 0, 5'd0, "R10 unknown address write");
    access(12'h8C3, OP_SET, 64'd1, 0, 5'd0, "R10 neighbour address");
    access(A_CLP, OP_WR, 64'd12, 0, 5'd0, "R2 write 12");
    access(A_CLP, OP_RD, 64'd3, 0, 5'd0, "R11 clamp alias read");
    access(A_SHD, OP_RD, 64'd63, 0, 5'd0, "R11 shadow read");
    access(A_MAX, OP_RD, 64'd1, 0, 5'd0, "R11 max read");
    idle();
    repeat (3) @(negedge clk);
    #4;
    checks++;
    if (q_due.size() != 0) begin
      fails++;
      $display("FAIL R11 scoreboard drain: actual %0d expected 0", q_due.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule